// File: doc/BRIEF.md
# Microsecond Slot Timer

This block keeps time for a time-slotted radio link. A fine counter advances once per microsecond tick and runs from zero up to a programmed window value, then wraps. Each wrap advances a slot counter, so one slot lasts the window value plus one microseconds. A window input of 4095 gives the longest slot, 4096 us. Integration logic normally resets the window value to 999, which gives a 1 ms slot.

A separate offset input selects the fine-count value inside each slot at which a slot event occurs. Each event raises a sticky event flag. If an event occurs while the event flag is still set, an overrun flag records that an interrupt was missed. Both flags drive one interrupt line through their own enable inputs.

Software controls the counters with three inputs. A hold input freezes both counters. A single-cycle upload pulse copies preset values into both counters. A clear pulse acknowledges the flags. All inputs are plain level or pulse signals. No data stream crosses the block edge, so there is no valid/ready handshake.

Top module: `slot_timer`

## Requirements
- R1: After reset, fine_cnt_o and slot_cnt_o are 0, both flags are 0 and irq_o is 0.
- R2: In an advancing cycle (tick_us_i=1, hold_i=0, upload_i=0) where fine_cnt_o < win_len_i, fine_cnt_o increases by one on that clock edge. In cycles with tick_us_i=0 and no upload, the counters do not change.
- R3: In an advancing cycle where fine_cnt_o >= win_len_i, fine_cnt_o becomes 0 and slot_cnt_o increases by one, modulo 2^SLOT_W. A slot therefore spans win_len_i+1 ticks.
- R4: When hold_i=1 and upload_i=0, neither counter changes and no slot event occurs. Ticks that arrive during hold are lost.
- R5: upload_i=1 loads fine_preset_i and slot_preset_i into the counters on that edge, whatever the values of hold_i and tick_us_i. An upload cycle never produces a slot event.
- R6: A slot event occurs in an advancing cycle whose new fine count equals evt_off_i, including 0 reached by a wrap. The event sets evt_flag_o. An offset above the window value never produces an event.
- R7: A slot event that occurs while evt_flag_o is already 1 sets ovr_flag_o, unless irq_clr_i is 1 in that same cycle.
- R8: irq_clr_i=1 clears both flags on that edge. If a slot event occurs in the same cycle, evt_flag_o is set again and ovr_flag_o is cleared.
- R9: irq_o is 1 exactly when (evt_flag_o and irq_en_evt_i) or (ovr_flag_o and irq_en_ovr_i). It follows enable changes in the same cycle.
- R10: Only irq_clr_i or reset clears the flags. Hold, upload and counter wraps leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle pulse each microsecond |
| win_len_i | input | FINE_W | Slot length minus one, in microseconds |
| evt_off_i | input | FINE_W | Fine count at which the slot event fires |
| fine_preset_i | input | FINE_W | Value that upload loads into the fine counter |
| slot_preset_i | input | SLOT_W | Value that upload loads into the slot counter |
| hold_i | input | 1 | Freeze both counters |
| upload_i | input | 1 | Load both presets (single-cycle pulse) |
| irq_clr_i | input | 1 | Clear event and overrun flags |
| irq_en_evt_i | input | 1 | Interrupt enable for the event flag |
| irq_en_ovr_i | input | 1 | Interrupt enable for the overrun flag |
| fine_cnt_o | output | FINE_W | Live fine count |
| slot_cnt_o | output | SLOT_W | Live slot count |
| evt_flag_o | output | 1 | Sticky slot-event flag |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong compare or next-value term in the fine counter is visible on fine_cnt_o one edge after the tick that exposes it. The same fault reaches slot_cnt_o at the next wrap, at most win_len_i+1 ticks later. A fault in the event path shows in one of two ways: evt_flag_o rises with fine_cnt_o different from the offset, or ovr_flag_o rises without a prior event flag. Both are observable on the edge where the event should or should not have occurred. Flag or enable errors reach irq_o in the same cycle, because the interrupt is purely combinational from the flags.

// File: rtl/slot_timer_pkg.sv
package slot_timer_pkg;
  // Operation applied to both counters in a cycle.
  typedef enum logic [1:0] {
    CNT_KEEP = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/st_op_decode.sv
module st_op_decode
  import slot_timer_pkg::*;
(
  input  logic    tick_us_i,
  input  logic    hold_i,
  input  logic    upload_i,
  output cnt_op_e op_o
);
  // Upload outranks hold, and hold outranks the tick.
  always_comb begin
    if (upload_i)
      op_o = CNT_LOAD;
    else if (hold_i)
      op_o = CNT_KEEP;
    else if (tick_us_i)
      op_o = CNT_STEP;
    else
      op_o = CNT_KEEP;
  end
endmodule

// File: rtl/st_fine_cnt.sv
module st_fine_cnt
  import slot_timer_pkg::*;
#(
  parameter int FINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cnt_op_e           op_i,
  input  logic [FINE_W-1:0] win_len_i,
  input  logic [FINE_W-1:0] preset_i,
  output logic [FINE_W-1:0] cnt_o,
  output logic [FINE_W-1:0] nxt_o,
  output logic              wrap_o
);
  logic [FINE_W-1:0] cnt_q;

  // A count at or above the window value ends the slot. The >= compare
  // also covers a window shrunk mid-slot and an oversized preset.
  always_comb begin
    wrap_o = (op_i == CNT_STEP) && (cnt_q >= win_len_i);
    unique case (op_i)
      CNT_LOAD: nxt_o = preset_i;
      CNT_STEP: nxt_o = wrap_o ? '0 : cnt_q + 1'b1;
      default:  nxt_o = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/st_slot_cnt.sv
module st_slot_cnt
  import slot_timer_pkg::*;
#(
  parameter int SLOT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cnt_op_e           op_i,
  input  logic              wrap_i,
  input  logic [SLOT_W-1:0] preset_i,
  output logic [SLOT_W-1:0] cnt_o
);
  logic [SLOT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (op_i == CNT_LOAD)   cnt_q <= preset_i;
    else if (wrap_i)             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/st_event_flags.sv
module st_event_flags
  import slot_timer_pkg::*;
#(
  parameter int FINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cnt_op_e           op_i,
  input  logic [FINE_W-1:0] fine_nxt_i,
  input  logic [FINE_W-1:0] evt_off_i,
  input  logic              clr_i,
  input  logic              en_evt_i,
  input  logic              en_ovr_i,
  output logic              evt_o,
  output logic              ovr_o,
  output logic              irq_o
);
  logic evt_q, ovr_q, hit;

  // Only an advancing cycle can land on the offset.
  assign hit = (op_i == CNT_STEP) && (fine_nxt_i == evt_off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      evt_q <= hit | (evt_q & ~clr_i);
      ovr_q <= ~clr_i & (ovr_q | (hit & evt_q));
    end
  end

  assign evt_o = evt_q;
  assign ovr_o = ovr_q;
  assign irq_o = (evt_q & en_evt_i) | (ovr_q & en_ovr_i);
endmodule

// File: rtl/slot_timer.sv
module slot_timer
  import slot_timer_pkg::*;
#(
  parameter int FINE_W = 12,
  parameter int SLOT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_us_i,
  input  logic [FINE_W-1:0] win_len_i,
  input  logic [FINE_W-1:0] evt_off_i,
  input  logic [FINE_W-1:0] fine_preset_i,
  input  logic [SLOT_W-1:0] slot_preset_i,
  input  logic              hold_i,
  input  logic              upload_i,
  input  logic              irq_clr_i,
  input  logic              irq_en_evt_i,
  input  logic              irq_en_ovr_i,
  output logic [FINE_W-1:0] fine_cnt_o,
  output logic [SLOT_W-1:0] slot_cnt_o,
  output logic              evt_flag_o,
  output logic              ovr_flag_o,
  output logic              irq_o
);
  cnt_op_e           op;
  logic [FINE_W-1:0] fine_nxt;
  logic              fine_wrap;

  st_op_decode u_dec (
    .tick_us_i (tick_us_i),
    .hold_i    (hold_i),
    .upload_i  (upload_i),
    .op_o      (op)
  );

  st_fine_cnt #(.FINE_W(FINE_W)) u_fine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .win_len_i (win_len_i),
    .preset_i  (fine_preset_i),
    .cnt_o     (fine_cnt_o),
    .nxt_o     (fine_nxt),
    .wrap_o    (fine_wrap)
  );

  st_slot_cnt #(.SLOT_W(SLOT_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .wrap_i   (fine_wrap),
    .preset_i (slot_preset_i),
    .cnt_o    (slot_cnt_o)
  );

  st_event_flags #(.FINE_W(FINE_W)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .fine_nxt_i (fine_nxt),
    .evt_off_i  (evt_off_i),
    .clr_i      (irq_clr_i),
    .en_evt_i   (irq_en_evt_i),
    .en_ovr_i   (irq_en_ovr_i),
    .evt_o      (evt_flag_o),
    .ovr_o      (ovr_flag_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/slot_timer_chk.sv
module slot_timer_chk #(
  parameter int FINE_W = 12,
  parameter int SLOT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_us_i,
  input logic [FINE_W-1:0] win_len_i,
  input logic [FINE_W-1:0] evt_off_i,
  input logic [FINE_W-1:0] fine_preset_i,
  input logic [SLOT_W-1:0] slot_preset_i,
  input logic              hold_i,
  input logic              upload_i,
  input logic              irq_clr_i,
  input logic [FINE_W-1:0] fine_cnt_o,
  input logic [SLOT_W-1:0] slot_cnt_o,
  input logic              evt_flag_o,
  input logic              ovr_flag_o,
  input logic              irq_o
);
  logic              adv;
  logic [FINE_W-1:0] fine_inc;
  logic [SLOT_W-1:0] slot_inc;
  assign adv      = tick_us_i && !hold_i && !upload_i;
  assign fine_inc = fine_cnt_o + 1'b1;
  assign slot_inc = slot_cnt_o + 1'b1;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && (fine_cnt_o < win_len_i) |=> fine_cnt_o == $past(fine_inc));
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && (fine_cnt_o >= win_len_i) |=> fine_cnt_o == '0 && slot_cnt_o == $past(slot_inc));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !upload_i |=> $stable(fine_cnt_o) && $stable(slot_cnt_o));
  a_r5_upload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upload_i |=> fine_cnt_o == $past(fine_preset_i) && slot_cnt_o == $past(slot_preset_i));
  a_r6_evt_at_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_flag_o) |-> fine_cnt_o == $past(evt_off_i));
  a_r7_ovr_needs_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_flag_o) |-> $past(evt_flag_o));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !tick_us_i |=> !evt_flag_o && !ovr_flag_o);
  a_r9_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> evt_flag_o || ovr_flag_o);
endmodule

bind slot_timer slot_timer_chk #(.FINE_W(FINE_W), .SLOT_W(SLOT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_us_i(tick_us_i), .win_len_i(win_len_i),
  .evt_off_i(evt_off_i), .fine_preset_i(fine_preset_i), .slot_preset_i(slot_preset_i),
  .hold_i(hold_i), .upload_i(upload_i), .irq_clr_i(irq_clr_i),
  .fine_cnt_o(fine_cnt_o), .slot_cnt_o(slot_cnt_o), .evt_flag_o(evt_flag_o),
  .ovr_flag_o(ovr_flag_o), .irq_o(irq_o)
);

// File: tb/slot_timer_tb_top.sv
`timescale 1ns/1ps
module slot_timer_tb_top;
  localparam int FW = 12;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, hold = 1'b0, upl = 1'b0, clr = 1'b0;
  logic en_evt = 1'b0, en_ovr = 1'b0;
  logic [FW-1:0] win = 12'd3, off = 12'd2, fpre = 12'd1;
  logic [SW-1:0] spre = 16'd5;
  logic [FW-1:0] fine;
  logic [SW-1:0] slot;
  logic evt, ovr, irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slot_timer #(.FINE_W(FW), .SLOT_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .win_len_i(win),
    .evt_off_i(off), .fine_preset_i(fpre), .slot_preset_i(spre),
    .hold_i(hold), .upload_i(upl), .irq_clr_i(clr),
    .irq_en_evt_i(en_evt), .irq_en_ovr_i(en_ovr),
    .fine_cnt_o(fine), .slot_cnt_o(slot), .evt_flag_o(evt),
    .ovr_flag_o(ovr), .irq_o(irq)
  );

  typedef struct packed {
    logic t, h, u, c;
    logic [11:0] f;
    logic [15:0] s;
    logic e, o;
  } vec_t;

  // win=3, off=2, fine preset 1, slot preset 5; expected state after each cycle
  localparam vec_t VECS [16] = '{
    '{1'b1,1'b0,1'b0,1'b0, 12'd1, 16'd0, 1'b0,1'b0},  // R2
    '{1'b1,1'b0,1'b0,1'b0, 12'd2, 16'd0, 1'b1,1'b0},  // R6 hit
    '{1'b1,1'b0,1'b0,1'b0, 12'd3, 16'd0, 1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b0, 12'd0, 16'd1, 1'b1,1'b0},  // R3 wrap
    '{1'b1,1'b1,1'b0,1'b0, 12'd0, 16'd1, 1'b1,1'b0},  // R4 hold
    '{1'b1,1'b0,1'b0,1'b0, 12'd1, 16'd1, 1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b0, 12'd2, 16'd1, 1'b1,1'b1},  // R7 overrun
    '{1'b0,1'b0,1'b0,1'b1, 12'd2, 16'd1, 1'b0,1'b0},  // R8 clear
    '{1'b1,1'b0,1'b1,1'b0, 12'd1, 16'd5, 1'b0,1'b0},  // R5 upload
    '{1'b1,1'b0,1'b0,1'b0, 12'd2, 16'd5, 1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b1, 12'd3, 16'd5, 1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0, 12'd0, 16'd6, 1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0, 12'd1, 16'd6, 1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0, 12'd2, 16'd6, 1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b1, 12'd3, 16'd6, 1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b0, 12'd3, 16'd6, 1'b0,1'b0}   // R2 no tick
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic h, input logic u, input logic c);
    tick = t; hold = h; upl = u; clr = c;
    @(posedge clk); #1;
    tick = 1'b0; hold = 1'b0; upl = 1'b0; clr = 1'b0;
  endtask

  initial begin
    #12; rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 fine", 32'(fine), 0); chk("R1 slot", 32'(slot), 0);
    chk("R1 flags", {30'd0, evt, ovr}, 0); chk("R1 irq", 32'(irq), 0);

    foreach (VECS[i]) begin
      step(VECS[i].t, VECS[i].h, VECS[i].u, VECS[i].c);
      chk($sformatf("vec%0d R2/R3/R4/R5 fine", i), 32'(fine), 32'(VECS[i].f));
      chk($sformatf("vec%0d R3/R5 slot", i), 32'(slot), 32'(VECS[i].s));
      chk($sformatf("vec%0d R6/R8 evt", i), 32'(evt), 32'(VECS[i].e));
      chk($sformatf("vec%0d R7/R8 ovr", i), 32'(ovr), 32'(VECS[i].o));
    end

    // R9 enables: from fine3 slot6, reach the offset
    step(1,0,0,0); step(1,0,0,0); step(1,0,0,0);
    chk("R6 evt at fine2", {31'd0, evt}, 1);
    chk("R9 irq masked", 32'(irq), 0);
    en_evt = 1'b1; #1; chk("R9 irq evt enabled", 32'(irq), 1);
    en_evt = 1'b0; en_ovr = 1'b1; #1; chk("R9 irq ovr only, ovr clear", 32'(irq), 0);
    for (int k = 0; k < 4; k++) step(1,0,0,0);
    chk("R7 second event sets ovr", 32'(ovr), 1);
    chk("R9 irq from ovr", 32'(irq), 1);
    en_ovr = 1'b0;

    // R10 flags survive upload and hold
    fpre = 12'd0; spre = 16'd0;
    step(1,1,1,0);
    chk("R5 upload over hold fine", 32'(fine), 0);
    chk("R5 upload over hold slot", 32'(slot), 0);
    step(1,1,0,0);
    chk("R10 flags kept", {30'd0, evt, ovr}, 3);

    // R8 event and clear in the same cycle
    step(1,0,0,0); step(1,0,1'b0,1);
    chk("R8 evt re-set on clear", 32'(evt), 1);
    chk("R8 ovr cleared", 32'(ovr), 0);

    // R6 offset 0 fires on the wrap
    step(0,0,0,1); off = 12'd0;
    step(1,0,0,0); step(1,0,0,0);
    chk("R6 offset0 fine", 32'(fine), 0);
    chk("R6 offset0 evt", 32'(evt), 1);

    // R6 offset above window never fires
    step(0,0,0,1); off = 12'd5;
    begin
      int seen = 0;
      for (int k = 0; k < 10; k++) begin step(1,0,0,0); seen += evt; end
      chk("R6 offset beyond window", 32'(seen), 0);
    end

    // R3 preset above the window wraps on the next tick
    fpre = 12'd9; spre = 16'd100;
    step(0,0,1,0); step(1,0,0,0);
    chk("R3 oversize fine", 32'(fine), 0);
    chk("R3 oversize slot", 32'(slot), 101);

    // R3 slot counter rollover
    fpre = 12'd3; spre = 16'hFFFF;
    step(0,0,1,0); step(1,0,0,0);
    chk("R3 rollover fine", 32'(fine), 0);
    chk("R3 rollover slot", 32'(slot), 0);

    // R3 slot length is win+1 ticks
    win = 12'd4;
    for (int k = 0; k < 4; k++) step(1,0,0,0);
    chk("R3 len mid fine", 32'(fine), 4);
    chk("R3 len mid slot", 32'(slot), 0);
    step(1,0,0,0);
    chk("R3 len end fine", 32'(fine), 0);
    chk("R3 len end slot", 32'(slot), 1);

    // R1 reset mid-run
    off = 12'd1; step(1,0,0,0);
    rst_n = 1'b0; #1;
    chk("R1 async reset", {fine, slot, evt, ovr, irq}, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule